// File: doc/BRIEF.md
# UART Channel Interrupt Mask and Bid Generator

This block sits beside one UART channel and turns its interrupt events into a single request with a priority number. Five event inputs (input change of state, receiver idle watchdog, address match, flow-control character match, break change) are captured into sticky status bits. Two more status bits follow the live receive-ready and transmit-ready levels of the channel FIFOs. A mask register picks which status bits may raise the active-low request line.

For every unmasked pending source the block forms a bid number. The bid joins a per-source priority prefix, the channel number and a fixed 3-bit source code, and the largest bid among the pending sources is presented. Four of the sources take their prefix from a programmable register. The watchdog, receive-ready and transmit-ready sources always use a prefix of zero. Software reads and writes the registers through a small synchronous port, and writes to the status address clear sticky bits.

Top module: `uart_irq_bid`

## Requirements
- R1: A one-cycle pulse on an event input sets its status bit at the next clock edge: change of state at bit 7, watchdog at bit 6, address match at bit 5, flow character at bit 4, break change at bit 2. The bit then stays set until it is cleared.
- R2: Status bit 3 always reads as 0.
- R3: Status bit 1 equals the receive-ready input and status bit 0 equals the transmit-ready input in the same cycle. Writes to the status address do not change either bit.
- R4: A write to register address 0 clears each sticky status bit whose data bit is 1 and leaves bits written with 0 unchanged. When an event and a clear reach the same bit in the same cycle, the bit is set.
- R5: irq_n is 0 exactly when some status bit and its mask bit (register address 1) are both 1. A masked pending bit has no effect on irq_n or the bid, and it stays in the status.
- R6: The bid is {prefix, chan_id, code}, where code is the status bit index. The prefix comes from register 2 for change of state, register 3 for break change, register 4 for flow character and register 5 for address match. It is 0 for the watchdog, receive-ready and transmit-ready sources.
- R7: When several unmasked sources are pending, bid_num carries the largest of their bids.
- R8: In registers 2 to 5 only the low 3 bits are stored. The upper bits read as 0 whatever was written. reg_rdata returns the addressed register in the same cycle.
- R9: After reset the status sticky bits, the mask and all prefix registers are 0, irq_n is 1 and bid_num is 0.
- R10: bid_num is 0 whenever irq_n is 1.
- R11: Register addresses 6 and 7 read as 0, and writes to them change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ev_cos | input | 1 | Input change-of-state event pulse |
| ev_wdog | input | 1 | Receiver idle watchdog event pulse |
| ev_addr | input | 1 | Address match event pulse |
| ev_xon | input | 1 | Flow-control character match event pulse |
| ev_brk | input | 1 | Break state change event pulse |
| rx_ready | input | 1 | Live receive FIFO service level |
| tx_ready | input | 1 | Live transmit FIFO service level |
| chan_id | input | CH_W | Channel number placed in the bid |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | REG_AW | Register address for read and write |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Read data of the addressed register |
| status | output | 8 | Interrupt status value |
| irq_n | output | 1 | Interrupt request, active low |
| bid_num | output | BID_MSB_W+CH_W+3 | Bid of the winning pending source |

## Verification
The bench builds the block with a 2-bit channel number, 3-bit prefixes, a 3-bit register address and the tree form of the maximum selector. With these values every channel number 0 to 3 and every prefix value 0 to 7 can reach the bid, so ordering by prefix, by source code and across the fixed-zero sources can all be checked against a behavioural model. Random register traffic that also touches the unmapped addresses 6 and 7 runs alongside random event pulses, so clear-versus-set collisions and masked pending sources occur many times.

// File: rtl/uart_irq_pkg.sv
package uart_irq_pkg;

   localparam int NUM_SRC = 8;
   localparam int SRC_W   = 3;
   localparam int NUM_BCR = 4;

   localparam int SRC_TX  = 0;
   localparam int SRC_RX  = 1;
   localparam int SRC_BRK = 2;
   localparam int SRC_RSV = 3;
   localparam int SRC_XON = 4;
   localparam int SRC_ADR = 5;
   localparam int SRC_WDG = 6;
   localparam int SRC_COS = 7;

   // which status bits are sticky, which follow a live level
   localparam logic [NUM_SRC-1:0] STICKY_MAP = 8'b1111_0100;
   localparam logic [NUM_SRC-1:0] LIVE_MAP   = 8'b0000_0011;

   // register addresses
   localparam int RA_STAT = 0;
   localparam int RA_MASK = 1;
   localparam int RA_BID0 = 2;

   // prefix register slot for a source, -1 when the prefix is fixed at zero
   function automatic int bcr_slot(int src);
      case (src)
         SRC_COS: return 0;
         SRC_BRK: return 1;
         SRC_XON: return 2;
         SRC_ADR: return 3;
         default: return -1;
      endcase
   endfunction

endpackage

// File: rtl/irq_status_reg.sv
module irq_status_reg
   import uart_irq_pkg::*;
(
   input  logic               clk,
   input  logic               rst_n,
   input  logic [NUM_SRC-1:0] set_pulse,
   input  logic [NUM_SRC-1:0] clr_req,
   input  logic [NUM_SRC-1:0] live_lvl,
   output logic [NUM_SRC-1:0] status
);

   for (genvar i = 0; i < NUM_SRC; i++) begin : g_bit
      if (STICKY_MAP[i]) begin : g_sticky
         logic q;
         logic unused_live;
         assign unused_live = live_lvl[i];
         always_ff @(posedge clk) begin
            if (!rst_n)            q <= 1'b0;
            else if (set_pulse[i]) q <= 1'b1;   // set wins over clear
            else if (clr_req[i])   q <= 1'b0;
         end
         assign status[i] = q;
      end else if (LIVE_MAP[i]) begin : g_live
         logic unused_ev;
         assign unused_ev = set_pulse[i] ^ clr_req[i];
         assign status[i] = live_lvl[i];
      end else begin : g_rsvd
         logic unused_all;
         assign unused_all = ^{set_pulse[i], clr_req[i], live_lvl[i]};
         assign status[i]  = 1'b0;
      end
   end

endmodule

// File: rtl/irq_cfg_regs.sv
module irq_cfg_regs
   import uart_irq_pkg::*;
#(
   parameter int REG_AW    = 3,
   parameter int BID_MSB_W = 3
)(
   input  logic                              clk,
   input  logic                              rst_n,
   input  logic                              wr_en,
   input  logic [REG_AW-1:0]                 addr,
   input  logic [NUM_SRC-1:0]                wdata,
   input  logic [NUM_SRC-1:0]                status,
   output logic [NUM_SRC-1:0]                mask_q,
   output logic [NUM_BCR-1:0][BID_MSB_W-1:0] bcr_q,
   output logic [NUM_SRC-1:0]                rdata,
   output logic [NUM_SRC-1:0]                clr_req
);

   logic sel_stat, sel_mask;
   assign sel_stat = (addr == REG_AW'(RA_STAT));
   assign sel_mask = (addr == REG_AW'(RA_MASK));

   always_ff @(posedge clk) begin
      if (!rst_n)                mask_q <= '0;
      else if (wr_en && sel_mask) mask_q <= wdata;
   end

   for (genvar k = 0; k < NUM_BCR; k++) begin : g_bcr
      logic                 sel;
      logic [BID_MSB_W-1:0] r;
      assign sel = (addr == REG_AW'(RA_BID0 + k));
      always_ff @(posedge clk) begin
         if (!rst_n)          r <= '0;
         else if (wr_en && sel) r <= wdata[BID_MSB_W-1:0];
      end
      assign bcr_q[k] = r;
   end

   always_comb begin
      rdata = '0;
      if (sel_stat) rdata = status;
      if (sel_mask) rdata = mask_q;
      for (int k = 0; k < NUM_BCR; k++) begin
         if (addr == REG_AW'(RA_BID0 + k)) rdata[BID_MSB_W-1:0] = bcr_q[k];
      end
   end

   assign clr_req = (wr_en && sel_stat) ? wdata : '0;

endmodule

// File: rtl/irq_bid_arbiter.sv
module irq_bid_arbiter
   import uart_irq_pkg::*;
#(
   parameter int CH_W      = 2,
   parameter int BID_MSB_W = 3,
   parameter int ARB_TREE  = 1,
   parameter int BID_W     = BID_MSB_W + CH_W + SRC_W
)(
   input  logic [NUM_SRC-1:0]                status,
   input  logic [NUM_SRC-1:0]                mask,
   input  logic [NUM_BCR-1:0][BID_MSB_W-1:0] bcr_q,
   input  logic [CH_W-1:0]                   chan,
   output logic [BID_W-1:0]                  bid,
   output logic                              irq_n
);

   logic [NUM_SRC-1:0] pend;
   logic [BID_W-1:0]   cand [NUM_SRC];

   assign pend  = status & mask;
   assign irq_n = ~|pend;

   for (genvar i = 0; i < NUM_SRC; i++) begin : g_cand
      localparam int SLOT = bcr_slot(i);
      logic [BID_MSB_W-1:0] pfx;
      if (SLOT >= 0) begin : g_prog
         assign pfx = bcr_q[SLOT];
      end else begin : g_fixed
         assign pfx = '0;
      end
      assign cand[i] = pend[i] ? {pfx, chan, SRC_W'(i)} : '0;
   end

   if (ARB_TREE != 0) begin : g_tree
      always_comb begin
         logic [BID_W-1:0] w [NUM_SRC];
         for (int i = 0; i < NUM_SRC; i++) w[i] = cand[i];
         for (int span = 1; span < NUM_SRC; span = span * 2) begin
            for (int j = 0; j + span < NUM_SRC; j = j + 2 * span) begin
               if (w[j + span] > w[j]) w[j] = w[j + span];
            end
         end
         bid = w[0];
      end
   end else begin : g_linear
      always_comb begin
         bid = '0;
         for (int i = 0; i < NUM_SRC; i++) begin
            if (cand[i] > bid) bid = cand[i];
         end
      end
   end

endmodule

// File: rtl/uart_irq_bid.sv
module uart_irq_bid
   import uart_irq_pkg::*;
#(
   parameter int CH_W      = 2,
   parameter int BID_MSB_W = 3,
   parameter int REG_AW    = 3,
   parameter int ARB_TREE  = 1
)(
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic                          ev_cos,
   input  logic                          ev_wdog,
   input  logic                          ev_addr,
   input  logic                          ev_xon,
   input  logic                          ev_brk,
   input  logic                          rx_ready,
   input  logic                          tx_ready,
   input  logic [CH_W-1:0]               chan_id,
   input  logic                          reg_wr,
   input  logic [REG_AW-1:0]             reg_addr,
   input  logic [7:0]                    reg_wdata,
   output logic [7:0]                    reg_rdata,
   output logic [7:0]                    status,
   output logic                          irq_n,
   output logic [BID_MSB_W+CH_W+3-1:0]   bid_num
);

   localparam int BID_W = BID_MSB_W + CH_W + SRC_W;

   if (CH_W < 1 || CH_W > 8) begin : g_chk_ch
      $error("uart_irq_bid: CH_W out of range");
   end
   if (BID_MSB_W < 1 || BID_MSB_W > 8) begin : g_chk_pfx
      $error("uart_irq_bid: BID_MSB_W out of range");
   end
   if (REG_AW < 3) begin : g_chk_aw
      $error("uart_irq_bid: REG_AW too small for the register map");
   end

   logic [NUM_SRC-1:0]                set_pulse, live_lvl, clr_req, mask_q;
   logic [NUM_BCR-1:0][BID_MSB_W-1:0] bcr_q;
   logic [BID_W-1:0]                  bid_w;

   always_comb begin
      set_pulse          = '0;
      set_pulse[SRC_COS] = ev_cos;
      set_pulse[SRC_WDG] = ev_wdog;
      set_pulse[SRC_ADR] = ev_addr;
      set_pulse[SRC_XON] = ev_xon;
      set_pulse[SRC_BRK] = ev_brk;
      live_lvl           = '0;
      live_lvl[SRC_RX]   = rx_ready;
      live_lvl[SRC_TX]   = tx_ready;
   end

   irq_status_reg u_stat (
      .clk       (clk),
      .rst_n     (rst_n),
      .set_pulse (set_pulse),
      .clr_req   (clr_req),
      .live_lvl  (live_lvl),
      .status    (status)
   );

   irq_cfg_regs #(
      .REG_AW    (REG_AW),
      .BID_MSB_W (BID_MSB_W)
   ) u_cfg (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (reg_wr),
      .addr    (reg_addr),
      .wdata   (reg_wdata),
      .status  (status),
      .mask_q  (mask_q),
      .bcr_q   (bcr_q),
      .rdata   (reg_rdata),
      .clr_req (clr_req)
   );

   irq_bid_arbiter #(
      .CH_W      (CH_W),
      .BID_MSB_W (BID_MSB_W),
      .ARB_TREE  (ARB_TREE),
      .BID_W     (BID_W)
   ) u_arb (
      .status (status),
      .mask   (mask_q),
      .bcr_q  (bcr_q),
      .chan   (chan_id),
      .bid    (bid_w),
      .irq_n  (irq_n)
   );

   assign bid_num = bid_w;

endmodule

// File: rtl/uart_irq_bid_chk.sv
module uart_irq_bid_chk #(
   parameter int CH_W      = 2,
   parameter int BID_MSB_W = 3,
   parameter int REG_AW    = 3
)(
   input logic                        clk,
   input logic                        rst_n,
   input logic                        ev_cos,
   input logic                        ev_brk,
   input logic                        ev_xon,
   input logic                        rx_ready,
   input logic                        tx_ready,
   input logic [CH_W-1:0]             chan_id,
   input logic                        reg_wr,
   input logic [REG_AW-1:0]           reg_addr,
   input logic [7:0]                  reg_wdata,
   input logic [7:0]                  status,
   input logic [7:0]                  mask_q,
   input logic                        irq_n,
   input logic [BID_MSB_W+CH_W+2:0]   bid_num
);

   logic stat_wr;
   assign stat_wr = reg_wr && (reg_addr == '0);

   p_set_cos_r1: assert property (@(posedge clk) disable iff (!rst_n)
      ev_cos |=> status[7]);

   p_set_brk_r1: assert property (@(posedge clk) disable iff (!rst_n)
      ev_brk |=> status[2]);

   p_hold_cos_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (status[7] && !(stat_wr && reg_wdata[7])) |=> status[7]);

   p_rsvd_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
      status[3] == 1'b0);

   p_live_r3: assert property (@(posedge clk) disable iff (!rst_n)
      status[1:0] == {rx_ready, tx_ready});

   p_clear_xon_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (stat_wr && reg_wdata[4] && !ev_xon) |=> !status[4]);

   p_irq_pend_r5: assert property (@(posedge clk) disable iff (!rst_n)
      irq_n == ((status & mask_q) == 8'h00));

   p_chan_field_r6: assert property (@(posedge clk) disable iff (!rst_n)
      !irq_n |-> (bid_num[3 +: CH_W] == chan_id));

   p_idle_bid_r10: assert property (@(posedge clk) disable iff (!rst_n)
      irq_n |-> (bid_num == '0));

endmodule

bind uart_irq_bid uart_irq_bid_chk #(
   .CH_W      (CH_W),
   .BID_MSB_W (BID_MSB_W),
   .REG_AW    (REG_AW)
) chk_i (
   .clk       (clk),
   .rst_n     (rst_n),
   .ev_cos    (ev_cos),
   .ev_brk    (ev_brk),
   .ev_xon    (ev_xon),
   .rx_ready  (rx_ready),
   .tx_ready  (tx_ready),
   .chan_id   (chan_id),
   .reg_wr    (reg_wr),
   .reg_addr  (reg_addr),
   .reg_wdata (reg_wdata),
   .status    (status),
   .mask_q    (mask_q),
   .irq_n     (irq_n),
   .bid_num   (bid_num)
);

// File: tb/uart_irq_bid_tb_top.sv
`timescale 1ns/1ps
module uart_irq_bid_tb_top;

   localparam int CH_W = 2;
   localparam int PW   = 3;
   localparam int AW   = 3;
   localparam int BW   = PW + CH_W + 3;

   logic            clk = 1'b0;
   logic            rst_n = 1'b0;
   logic            ev_cos = 0, ev_wdog = 0, ev_addr = 0, ev_xon = 0, ev_brk = 0;
   logic            rx_ready = 0, tx_ready = 0;
   logic [CH_W-1:0] chan_id = 2;
   logic            reg_wr = 0;
   logic [AW-1:0]   reg_addr = 0;
   logic [7:0]      reg_wdata = 0;
   logic [7:0]      reg_rdata, status;
   logic            irq_n;
   logic [BW-1:0]   bid_num;

   int nchk = 0;
   int nerr = 0;
   bit done = 0;

   // reference model state
   logic [7:0] m_sticky = 0;
   logic [7:0] m_mask = 0;
   logic [PW-1:0] m_pfx [4] = '{default: '0};

   always #4 clk = ~clk;

   uart_irq_bid #(.CH_W(CH_W), .BID_MSB_W(PW), .REG_AW(AW), .ARB_TREE(1)) dut_i (
      .clk(clk), .rst_n(rst_n), .ev_cos(ev_cos), .ev_wdog(ev_wdog), .ev_addr(ev_addr),
      .ev_xon(ev_xon), .ev_brk(ev_brk), .rx_ready(rx_ready), .tx_ready(tx_ready),
      .chan_id(chan_id), .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
      .reg_rdata(reg_rdata), .status(status), .irq_n(irq_n), .bid_num(bid_num)
   );

   function automatic logic [7:0] exp_status();
      return m_sticky | {6'b0, rx_ready, tx_ready};
   endfunction

   function automatic int pfx_of(int src);
      case (src)
         7: return int'(m_pfx[0]);
         2: return int'(m_pfx[1]);
         4: return int'(m_pfx[2]);
         5: return int'(m_pfx[3]);
         default: return 0;
      endcase
   endfunction

   function automatic int exp_bid();
      logic [7:0] p = exp_status() & m_mask;
      int best = 0;
      for (int i = 0; i < 8; i++) begin
         if (p[i]) begin
            int c = pfx_of(i) * (1 << (CH_W + 3)) + int'(chan_id) * 8 + i;
            if (c > best) best = c;
         end
      end
      return best;
   endfunction

   function automatic int exp_rdata();
      case (int'(reg_addr))
         0: return int'(exp_status());
         1: return int'(m_mask);
         2, 3, 4, 5: return int'(m_pfx[int'(reg_addr) - 2]);
         default: return 0;
      endcase
   endfunction

   task automatic chk(string tag, string what, int act, int exp);
      nchk++;
      if (act != exp) begin
         nerr++;
         $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
      end
   endtask

   task automatic compare_all();
      chk("R1", "status", int'(status), int'(exp_status()));
      chk("R2", "status bit3", int'(status[3]), 0);
      chk("R5", "irq_n", int'(irq_n), ((exp_status() & m_mask) == 0) ? 1 : 0);
      chk("R7", "bid_num", int'(bid_num), exp_bid());
      chk("R8", "reg_rdata", int'(reg_rdata), exp_rdata());
   endtask

   task automatic tick();
      logic [7:0] clr, setv;
      #1 compare_all();
      @(posedge clk);
      clr  = (reg_wr && reg_addr == 0) ? (reg_wdata & 8'hF4) : 8'h00;
      setv = {ev_cos, ev_wdog, ev_addr, ev_xon, 1'b0, ev_brk, 2'b00};
      m_sticky = (m_sticky & ~clr) | setv;
      if (reg_wr) begin
         if (reg_addr == 1) m_mask = reg_wdata;
         if (reg_addr >= 2 && reg_addr <= 5) m_pfx[int'(reg_addr) - 2] = reg_wdata[PW-1:0];
      end
      @(negedge clk);
      {ev_cos, ev_wdog, ev_addr, ev_xon, ev_brk, reg_wr} = '0;
      #1;
   endtask

   task automatic wr(int a, int d);
      reg_wr = 1; reg_addr = AW'(a); reg_wdata = 8'(d);
      tick();
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         nchk++; nerr++;
         $display("FAIL watchdog actual=timeout expected=finished");
         $display("Result: errors=%0d of %0d checks", nerr, nchk);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1;
      #1;
      // R9 reset state
      chk("R9", "status after reset", int'(status), 0);
      chk("R9", "irq_n after reset", int'(irq_n), 1);
      chk("R9", "bid after reset", int'(bid_num), 0);
      reg_addr = 1; #1;
      chk("R9", "mask after reset", int'(reg_rdata), 0);
      reg_addr = 2; #1;
      chk("R9", "prefix after reset", int'(reg_rdata), 0);

      wr(1, 8'hFF);
      wr(2, 8'h05);
      wr(3, 8'hFA);
      wr(4, 8'h07);
      wr(5, 8'h01);
      reg_addr = 3; #1;
      chk("R8", "prefix upper bits dropped", int'(reg_rdata), 2);

      ev_cos = 1; tick();
      chk("R1", "cos bit set", int'(status[7]), 1);
      chk("R6", "cos bid", int'(bid_num), 8'hB7);
      chk("R5", "irq asserted", int'(irq_n), 0);
      tick(); tick(); tick();
      chk("R1", "cos bit held", int'(status[7]), 1);

      ev_xon = 1; tick();
      chk("R7", "xon outranks cos", int'(bid_num), 8'hF4);

      wr(0, 8'h10);
      chk("R4", "xon cleared", int'(status), 8'h80);
      chk("R7", "cos after clear", int'(bid_num), 8'hB7);

      rx_ready = 1;
      wr(0, 8'h0B);
      chk("R3", "rx level not cleared", int'(status[1]), 1);
      chk("R2", "bit3 stays 0", int'(status[3]), 0);
      rx_ready = 0; #1;
      chk("R3", "rx follows level", int'(status[1]), 0);

      ev_addr = 1;
      wr(0, 8'h20);
      chk("R4", "set wins over clear", int'(status[5]), 1);
      wr(0, 8'h00);
      chk("R4", "write 0 keeps bits", int'(status), 8'hA0);

      wr(1, 8'h20);
      chk("R6", "address bid", int'(bid_num), 8'h35);
      chk("R5", "cos masked off", int'(status[7]), 1);
      wr(1, 8'h00);
      chk("R5", "all masked irq_n", int'(irq_n), 1);
      chk("R10", "all masked bid", int'(bid_num), 0);

      wr(1, 8'h04);
      ev_brk = 1; tick();
      chk("R6", "break bid", int'(bid_num), 8'h52);
      wr(1, 8'h40);
      ev_wdog = 1; tick();
      chk("R6", "watchdog fixed prefix", int'(bid_num), 8'h16);
      chan_id = 3; #1;
      chk("R6", "channel field", int'(bid_num), 8'h1E);

      wr(6, 8'hFF);
      wr(7, 8'hFF);
      reg_addr = 6; #1;
      chk("R11", "addr6 reads 0", int'(reg_rdata), 0);
      reg_addr = 7; #1;
      chk("R11", "addr7 reads 0", int'(reg_rdata), 0);
      reg_addr = 1; #1;
      chk("R11", "mask untouched", int'(reg_rdata), 8'h40);

      for (int n = 0; n < 600; n++) begin
         ev_cos  = ($urandom_range(0, 7) == 0);
         ev_wdog = ($urandom_range(0, 7) == 0);
         ev_addr = ($urandom_range(0, 7) == 0);
         ev_xon  = ($urandom_range(0, 7) == 0);
         ev_brk  = ($urandom_range(0, 7) == 0);
         rx_ready = $urandom_range(0, 1) == 1;
         tx_ready = $urandom_range(0, 1) == 1;
         chan_id  = CH_W'($urandom_range(0, 3));
         reg_addr = AW'($urandom_range(0, 7));
         reg_wdata = 8'($urandom_range(0, 255));
         reg_wr   = ($urandom_range(0, 2) == 0);
         tick();
      end

      done = 1;
      $display("Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
   end

endmodule